// File: doc/BRIEF.md
# Bus fault status register

This block gathers error indications from the bus into one 16-bit sticky fault word. It captures three active-low error inputs only at the end of a bus cycle, which is the clock edge at which the bus-busy input is first seen low after being high. The cycle qualifiers present at that edge decide which bit each error sets. The protect error goes to one of two bits depending on the bus master. The external address error goes to one of two bits depending on whether the cycle addresses memory or I/O. The parity error always goes to the same bit.

Two asynchronous system-fault inputs are synchronized and edge-detected. Fault 0 sets a single bit. Fault 1 sets two bits at once. Software reads the word from `fault_o` and clears bits by writing ones. The interrupt request is high whenever any fault bit is set.

Top module: `bus_fault_reg`

## Requirements
- R1: After reset, `fault_o` is 16'h0000 and `irq_o` is 0.
- R2: At the bus-cycle end (the first clock edge with `bus_busy_i` = 0 after an edge with `bus_busy_i` = 1), a low `prot_err_ni` sets bit 0 when `cyc_cpu_i` = 1 and bit 1 when `cyc_cpu_i` = 0. The new value is visible after that edge.
- R3: At the bus-cycle end, a low `par_err_ni` sets bit 2, whatever the qualifiers are.
- R4: At the bus-cycle end, a low `addr_err_ni` sets bit 5 when `cyc_io_i` = 0 (memory cycle) and bit 8 when `cyc_io_i` = 1 (I/O cycle).
- R5: The synchronous error inputs have no effect on any edge that is not a bus-cycle end. This covers `bus_busy_i` held high, `bus_busy_i` held low, and `bus_busy_i` rising.
- R6: A rising edge on `sys_flt_i[0]` sets bit 7 on the third clock edge after the input changes: two synchronizer stages plus one edge-detect stage. The bit is not set before that edge. Holding the input high does not set the bit again after it is cleared.
- R7: A rising edge on `sys_flt_i[1]` sets bits 13 and 15 together, with the same latency as R6.
- R8: Set bits stay set until a clock edge with `clr_we_i` = 1 and the matching `clr_data_i` bit = 1. Zero bits in `clr_data_i` leave their fault bits unchanged.
- R9: When a set and a clear of the same bit fall on the same edge, the bit ends up set.
- R10: `irq_o` is 1 exactly when `fault_o` is nonzero.
- R11: Bits 3, 4, 6, 9 to 12 and 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_busy_i | input | 1 | Bus busy; a high-to-low change ends a cycle |
| cyc_cpu_i | input | 1 | 1 = CPU-mastered cycle, 0 = other master |
| cyc_io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| prot_err_ni | input | 1 | Protect error, active low |
| par_err_ni | input | 1 | Memory parity error, active low |
| addr_err_ni | input | 1 | External address error, active low |
| sys_flt_i | input | 2 | Asynchronous system-fault inputs, rising-edge active |
| clr_we_i | input | 1 | Clear strobe |
| clr_data_i | input | 16 | Write-one-to-clear mask |
| fault_o | output | 16 | Fault word |
| irq_o | output | 1 | Summary interrupt request |

## Verification
The bench sweeps every combination of the three error inputs against both qualifiers. A design that swapped the master or the space qualifier would set a neighbouring bit, and the word comparison reveals it. Errors are also driven while busy is held high, held low and rising. A level-sampled design would latch them there and show a nonzero word. Asynchronous faults are checked edge by edge, so a missing synchronizer stage sets the bit one edge early. A level detector sets the bit again after it is cleared. A clear written on the same edge as a set must lose, or the set bit would read back as zero.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;
  localparam int FLT_W = 16;
  localparam int N_SYS = 2;

  // bit positions fixed by software decoding
  localparam int B_PROT_CPU = 0;
  localparam int B_PROT_EXT = 1;
  localparam int B_PARITY   = 2;
  localparam int B_ADDR_MEM = 5;
  localparam int B_SYS0     = 7;
  localparam int B_ADDR_IO  = 8;
  localparam int B_SYS1_A   = 13;
  localparam int B_SYS1_B   = 15;

  function automatic logic [FLT_W-1:0] bit_of(int pos);
    logic [FLT_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [FLT_W-1:0] sys_mask(int idx);
    case (idx)
      0:       return bit_of(B_SYS0);
      1:       return bit_of(B_SYS1_A) | bit_of(B_SYS1_B);
      default: return '0;
    endcase
  endfunction

  localparam logic [FLT_W-1:0] IMPL_MASK =
      bit_of(B_PROT_CPU) | bit_of(B_PROT_EXT) | bit_of(B_PARITY) |
      bit_of(B_ADDR_MEM) | bit_of(B_ADDR_IO)  | sys_mask(0) | sys_mask(1);
endpackage

// File: rtl/bus_fault_edge_sync.sv
module bus_fault_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int SR_W = STAGES + 1;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-2:0], async_i};
  end

  // sr_q[STAGES-1] is the last synchronizer flop, sr_q[STAGES] its history
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/bus_fault_route.sv
module bus_fault_route
  import bus_fault_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_busy_i,
  input  logic             cyc_cpu_i,
  input  logic             cyc_io_i,
  input  logic             prot_err_ni,
  input  logic             par_err_ni,
  input  logic             addr_err_ni,
  output logic [FLT_W-1:0] set_o
);
  logic busy_q;
  logic cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= bus_busy_i;
  end

  assign cyc_end = busy_q & ~bus_busy_i;

  always_comb begin
    set_o = '0;
    if (cyc_end) begin
      if (!prot_err_ni) set_o |= cyc_cpu_i ? bit_of(B_PROT_CPU) : bit_of(B_PROT_EXT);
      if (!par_err_ni)  set_o |= bit_of(B_PARITY);
      if (!addr_err_ni) set_o |= cyc_io_i ? bit_of(B_ADDR_IO) : bit_of(B_ADDR_MEM);
    end
  end
endmodule

// File: rtl/bus_fault_bank.sv
module bus_fault_bank
  import bus_fault_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FLT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [FLT_W-1:0] clr_data_i,
  output logic [FLT_W-1:0] q_o
);
  logic [FLT_W-1:0] q_q, clr_v, q_d;

  assign clr_v = clr_we_i ? clr_data_i : '0;
  // set wins over clear; unimplemented bits held at zero
  assign q_d   = ((q_q & ~clr_v) | set_i) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bus_fault_reg.sv
module bus_fault_reg
  import bus_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_busy_i,
  input  logic             cyc_cpu_i,
  input  logic             cyc_io_i,
  input  logic             prot_err_ni,
  input  logic             par_err_ni,
  input  logic             addr_err_ni,
  input  logic [N_SYS-1:0] sys_flt_i,
  input  logic             clr_we_i,
  input  logic [FLT_W-1:0] clr_data_i,
  output logic [FLT_W-1:0] fault_o,
  output logic             irq_o
);
  logic [FLT_W-1:0] bus_set, sys_set, all_set;
  logic [N_SYS-1:0] sys_rise;

  bus_fault_route u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_busy_i  (bus_busy_i),
    .cyc_cpu_i   (cyc_cpu_i),
    .cyc_io_i    (cyc_io_i),
    .prot_err_ni (prot_err_ni),
    .par_err_ni  (par_err_ni),
    .addr_err_ni (addr_err_ni),
    .set_o       (bus_set)
  );

  for (genvar k = 0; k < N_SYS; k++) begin : g_sys
    bus_fault_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (sys_flt_i[k]),
      .rise_o  (sys_rise[k])
    );
  end

  always_comb begin
    sys_set = '0;
    for (int k = 0; k < N_SYS; k++)
      if (sys_rise[k]) sys_set |= sys_mask(k);
  end

  assign all_set = bus_set | sys_set;

  bus_fault_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (all_set),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .q_o        (fault_o)
  );

  assign irq_o = |fault_o;
endmodule

// File: rtl/bus_fault_reg_chk.sv
module bus_fault_reg_chk
  import bus_fault_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_busy_i,
  input logic             cyc_cpu_i,
  input logic             cyc_io_i,
  input logic             prot_err_ni,
  input logic             par_err_ni,
  input logic             addr_err_ni,
  input logic             clr_we_i,
  input logic [FLT_W-1:0] clr_data_i,
  input logic [FLT_W-1:0] fault_o,
  input logic             irq_o
);
  logic             busy_prev;
  logic             end_c;
  logic [FLT_W-1:0] keep_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_prev <= 1'b0;
    else         busy_prev <= bus_busy_i;
  end

  assign end_c  = busy_prev & ~bus_busy_i;
  assign keep_c = fault_o & ~(clr_we_i ? clr_data_i : '0);

  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o & ~IMPL_MASK) == '0);

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fault_o & $past(keep_c)) == $past(keep_c)));

  // R10
  irq_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (fault_o != '0));

  // R10
  irq_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (fault_o == '0));

  // R2
  prot_cpu_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[B_PROT_CPU]) |-> $past(end_c && !prot_err_ni && cyc_cpu_i));

  // R4
  addr_io_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o[B_ADDR_IO]) |-> $past(end_c && !addr_err_ni && cyc_io_i));

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_c && !par_err_ni && clr_we_i && clr_data_i[B_PARITY]) |=> fault_o[B_PARITY]);
endmodule

bind bus_fault_reg bus_fault_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_busy_i  (bus_busy_i),
  .cyc_cpu_i   (cyc_cpu_i),
  .cyc_io_i    (cyc_io_i),
  .prot_err_ni (prot_err_ni),
  .par_err_ni  (par_err_ni),
  .addr_err_ni (addr_err_ni),
  .clr_we_i    (clr_we_i),
  .clr_data_i  (clr_data_i),
  .fault_o     (fault_o),
  .irq_o       (irq_o)
);

// File: tb/bus_fault_reg_bench.sv
module bus_fault_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0, cpu = 1'b0, io = 1'b0;
  logic        prot_n = 1'b1, par_n = 1'b1, addr_n = 1'b1;
  logic [1:0]  sys = 2'b00;
  logic        clr_we = 1'b0;
  logic [15:0] clr_data = '0;
  logic [15:0] fault;
  logic        irq;
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;

  localparam logic [15:0] RSVD = 16'h5E58; // bits 3,4,6,9-12,14

  always #2 clk = ~clk;

  bus_fault_reg u_bus_fault_reg (
    .clk_i(clk), .rst_ni(rst_n), .bus_busy_i(busy), .cyc_cpu_i(cpu),
    .cyc_io_i(io), .prot_err_ni(prot_n), .par_err_ni(par_n),
    .addr_err_ni(addr_n), .sys_flt_i(sys), .clr_we_i(clr_we),
    .clr_data_i(clr_data), .fault_o(fault), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req);
    total++;
    if (irq !== (fault != 0)) begin
      bad++;
      $display("FAIL %s: irq got %b expected %b", req, irq, fault != 0);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_we = 1'b1; clr_data = 16'hFFFF;
    tick();
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1", fault, 16'h0000);
    chk("R1", {15'b0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R10 R11: full sweep of errors x qualifiers
    for (int m = 0; m < 32; m++) begin
      logic [15:0] exp;
      clear_all();
      busy = 1'b1; prot_n = 1'b0; par_n = 1'b0; addr_n = 1'b0;
      tick();
      chk("R5 busy high", fault, 16'h0000);
      @(negedge clk);
      busy = 1'b0; prot_n = ~m[0]; par_n = ~m[1]; addr_n = ~m[2];
      cpu = m[3]; io = m[4];
      exp = 16'h0000;
      if (m[0]) exp |= m[3] ? 16'h0001 : 16'h0002;
      if (m[1]) exp |= 16'h0004;
      if (m[2]) exp |= m[4] ? 16'h0100 : 16'h0020;
      tick();
      chk("R2/R3/R4 route", fault, exp);
      chk("R11 reserved", fault & RSVD, 16'h0000);
      chk_irq("R10");
      @(negedge clk); prot_n = 1'b1; par_n = 1'b1; addr_n = 1'b1;
    end

    // R5: busy held low, then rising, with all errors active
    clear_all();
    prot_n = 1'b0; par_n = 1'b0; addr_n = 1'b0;
    tick(); tick();
    chk("R5 busy low", fault, 16'h0000);
    @(negedge clk); busy = 1'b1;
    tick();
    chk("R5 busy rise", fault, 16'h0000);
    chk_irq("R10 idle");
    @(negedge clk); busy = 1'b0; prot_n = 1'b1; par_n = 1'b1; addr_n = 1'b1;
    cpu = 1'b1; io = 1'b0;
    tick();
    chk("R5 end no error", fault, 16'h0000);

    // R6: sync latency and level insensitivity
    @(negedge clk); sys[0] = 1'b1;
    tick(); chk("R6 edge1", fault, 16'h0000);
    tick(); chk("R6 edge2", fault, 16'h0000);
    tick(); chk("R6 edge3", fault, 16'h0080);
    clear_all();
    tick(); tick(); tick();
    chk("R6 level held", fault, 16'h0000);
    @(negedge clk); sys[0] = 1'b0;

    // R7 then R8 partial clear
    @(negedge clk); sys[1] = 1'b1;
    tick(); tick();
    chk("R7 early", fault, 16'h0000);
    tick();
    chk("R7 set", fault, 16'hA000);
    @(negedge clk); sys[1] = 1'b0; clr_we = 1'b1; clr_data = 16'h2000;
    tick();
    chk("R8 partial clear", fault, 16'h8000);
    @(negedge clk); clr_data = 16'h5E58;
    tick();
    chk("R8/R11 clear zeros", fault, 16'h8000);
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
    tick(); tick();
    chk("R8 hold", fault, 16'h8000);
    chk_irq("R10 held");

    // R9: set and clear on the same edge
    clear_all();
    busy = 1'b1;
    tick();
    @(negedge clk);
    busy = 1'b0; par_n = 1'b0; addr_n = 1'b0; io = 1'b1;
    clr_we = 1'b1; clr_data = 16'h0004;
    tick();
    chk("R9 set wins", fault, 16'h0104);
    @(negedge clk); par_n = 1'b1; addr_n = 1'b1; clr_data = 16'h0104;
    tick();
    chk("R8 clear", fault, 16'h0000);
    chk_irq("R10 cleared");
    @(negedge clk); clr_we = 1'b0; clr_data = '0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule